// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. It fetches from a private instruction store and reads or writes a separate data store in the same cycle, so no cycle is ever shared between fetch and data access. The core runs register-to-register arithmetic and logic (add, subtract, and, or, signed set-less-than), word loads and stores, branch-if-equal and an absolute jump. It holds 32 general registers, a program counter, one ALU and two dedicated address adders for the next-PC paths.

Control is decoded in two levels. A main decoder looks only at opcode bits 31-26 and produces the datapath selects plus a two-bit operation class. A second decoder turns that class, together with function bits 5-0 for register-form instructions, into the three-bit ALU control code. The operation class 2'b11 is never produced.

A test harness fills both stores through plain load ports while reset is held, then releases reset and reads results back through a data-store observe port. The load ports carry no valid/ready pair: they never push back, and a word is written on every rising edge where its enable is high. The observe port reads combinationally. A status pin flags signed overflow of the add or subtract in progress.

Top module: `scp_core`

## Requirements
- R1: While rst_n is low the PC is held at 0 and the core writes neither a register nor the data store; the first instruction after release is fetched from byte address 0.
- R2: The PC is byte-addressed and word-aligned; every instruction that is neither a taken branch nor a jump moves it to PC+4 at the next edge, with no enable.
- R3: Opcode 0x00 selects register form: rs = bits 25-21, rt = bits 20-16, rd = bits 15-11, shamt = bits 10-6 (must be 0), function = bits 5-0; function 0x20 adds, 0x22 subtracts (rs-rt), 0x24 ANDs and 0x25 ORs, each wrapping modulo 2^32 and written to rd.
- R4: Function 0x2A compares rs and rt as signed two's-complement values and writes 1 to rd when rs < rt, else 0.
- R5: Opcode 0x23 loads the data word at rs + sign-extended bits 15-0 into rt; opcode 0x2B stores rt there. Addresses are bytes, the store is word-indexed by address bits [DAW+1:2]; stores, branches and jumps never write a register.
- R6: Opcode 0x04 compares rs and rt; when equal the next PC is PC+4 + (sign-extended bits 15-0 shifted left by 2), otherwise PC+4. Negative offsets branch backwards.
- R7: Opcode 0x02 sets the next PC to {PC+4 bits 31-28, bits 25-0, 2'b00}.
- R8: Register 0 always reads as zero; writes to it, by arithmetic or load, are discarded.
- R9: An unknown opcode, an unsupported function code, or a register-form word with non-zero shamt writes no register and no data word, and the PC advances by 4.
- R10: alu_ovf is high during a cycle whose ALU operation is add or subtract and whose signed result overflows; it is low for and, or and set-less-than.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of PC and registers |
| imem_ld_en | input | 1 | Write enable for the instruction store load port |
| imem_ld_addr | input | IAW | Word index into the instruction store |
| imem_ld_data | input | 32 | Instruction word to write |
| dmem_ld_en | input | 1 | Write enable for the data store load port (wins over a core store) |
| dmem_ld_addr | input | DAW | Word index into the data store |
| dmem_ld_data | input | 32 | Data word to write |
| dmem_obs_addr | input | DAW | Word index read by the observe port |
| dmem_obs_data | output | 32 | Combinational read of the addressed data word |
| alu_ovf | output | 1 | Signed overflow of the current add or subtract |

## Verification
The bench builds the core with its default store depths of 64 words each, which lets every directed program, its halt loop and its data image fit while keeping the top address nibble of the PC at zero. That depth still reaches backward branches with negative offsets, negative load/store displacements against a base register, and a jump that skips forward over stores. Cycle-exact sampling after reset release lets the overflow pin be checked instruction by instruction, while all other results are read back through the observe port once the program has reached its self-jump.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int XLEN = 32;

  // Opcode field values (bits 31-26)
  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  // Function field values (bits 5-0) for register form
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_ctl_e;

  typedef enum logic [1:0] {
    OPCL_ADD   = 2'b00,
    OPCL_SUB   = 2'b01,
    OPCL_FUNCT = 2'b10
  } op_class_e;

  typedef struct packed {
    logic      dst_is_rd;
    logic      b_is_imm;
    logic      wb_from_mem;
    logic      reg_write;
    logic      mem_read;
    logic      mem_write;
    logic      branch;
    logic      jump;
    op_class_e op_class;
  } ctrl_t;

endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctrl_t      ctrl,
  output alu_ctl_e   alu_ctl,
  output logic       op_legal
);

  // Level 1: opcode only
  always_comb begin
    ctrl          = '0;
    ctrl.op_class = OPCL_ADD;
    unique case (opcode)
      OPC_REG: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.op_class  = OPCL_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_write   = 1'b1;
        ctrl.mem_read    = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_is_imm  = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch   = 1'b1;
        ctrl.op_class = OPCL_SUB;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

  logic opc_known;
  assign opc_known = (opcode == OPC_REG) || (opcode == OPC_LOAD) ||
                     (opcode == OPC_STORE) || (opcode == OPC_BEQ) ||
                     (opcode == OPC_JUMP);

  // Level 2: operation class plus function field
  logic fn_ok;
  always_comb begin
    alu_ctl = ALU_ADD;
    fn_ok   = 1'b1;
    case (ctrl.op_class)
      OPCL_ADD: alu_ctl = ALU_ADD;
      OPCL_SUB: alu_ctl = ALU_SUB;
      OPCL_FUNCT: begin
        case (funct)
          FN_ADD:  alu_ctl = ALU_ADD;
          FN_SUB:  alu_ctl = ALU_SUB;
          FN_AND:  alu_ctl = ALU_AND;
          FN_OR:   alu_ctl = ALU_OR;
          FN_SLT:  alu_ctl = ALU_SLT;
          default: fn_ok   = 1'b0;
        endcase
        if (shamt != 5'd0) fn_ok = 1'b0;
      end
      default: fn_ok = 1'b0;
    endcase
  end

  assign op_legal = opc_known && fn_ok;

endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_ctl_e     ctl,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         ovf
);

  always_comb begin
    y   = '0;
    ovf = 1'b0;
    case (ctl)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: begin
        y   = a + b;
        ovf = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
      end
      ALU_SUB: begin
        y   = a - b;
        ovf = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
      end
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/scp_next_pc.sv
module scp_next_pc #(
  parameter int W = 32
) (
  input  logic [W-1:0] pc,
  input  logic [15:0]  br_off,
  input  logic [25:0]  jmp_field,
  input  logic         take_branch,
  input  logic         take_jump,
  output logic [W-1:0] pc_next
);

  logic [W-1:0] pc_seq, pc_br, pc_jmp, br_disp;

  // Sequential adder
  assign pc_seq  = pc + W'(4);
  // Branch adder, separate from the ALU
  assign br_disp = {{(W-18){br_off[15]}}, br_off, 2'b00};
  assign pc_br   = pc_seq + br_disp;
  // Jump path: region bits from PC+4, field shifted by 2
  assign pc_jmp  = {pc_seq[W-1:W-4], jmp_field, 2'b00};

  always_comb begin
    if (take_jump)        pc_next = pc_jmp;
    else if (take_branch) pc_next = pc_br;
    else                  pc_next = pc_seq;
  end

endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int IAW = 6,
  parameter int DAW = 6,
  localparam int IDEPTH = 1 << IAW,
  localparam int DDEPTH = 1 << DAW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           imem_ld_en,
  input  logic [IAW-1:0] imem_ld_addr,
  input  logic [31:0]    imem_ld_data,
  input  logic           dmem_ld_en,
  input  logic [DAW-1:0] dmem_ld_addr,
  input  logic [31:0]    dmem_ld_data,
  input  logic [DAW-1:0] dmem_obs_addr,
  output logic [31:0]    dmem_obs_data,
  output logic           alu_ovf
);

  logic [31:0] pc, pc_next, instr;
  logic [31:0] imem [IDEPTH];
  logic [31:0] dmem [DDEPTH];

  // Instruction store: harness writes, core reads every cycle
  always_ff @(posedge clk) begin
    if (imem_ld_en) imem[imem_ld_addr] <= imem_ld_data;
  end

  logic fetch_ok;
  assign fetch_ok = (pc[1:0] == 2'b00) && (pc[31:IAW+2] == '0);
  assign instr    = fetch_ok ? imem[pc[IAW+1:2]] : '0;

  // Fields
  logic [5:0]  f_opc, f_fn;
  logic [4:0]  f_rs, f_rt, f_rd, f_sh;
  logic [15:0] f_imm;
  assign f_opc = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_sh  = instr[10:6];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];

  ctrl_t    ctrl;
  alu_ctl_e alu_ctl;
  logic     op_legal;

  scp_decode u_dec (
    .opcode  (f_opc),
    .funct   (f_fn),
    .shamt   (f_sh),
    .ctrl    (ctrl),
    .alu_ctl (alu_ctl),
    .op_legal(op_legal)
  );

  logic [31:0] rs_val, rt_val, wb_val, alu_b, alu_y, sext;
  logic [4:0]  rf_wa;
  logic        rf_we, alu_zero;

  assign sext  = {{16{f_imm[15]}}, f_imm};
  assign rf_wa = ctrl.dst_is_rd ? f_rd : f_rt;
  assign rf_we = ctrl.reg_write && op_legal && rst_n;

  scp_regfile #(.W(32), .N(32)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .ra1  (f_rs),
    .ra2  (f_rt),
    .rd1  (rs_val),
    .rd2  (rt_val),
    .we   (rf_we),
    .wa   (rf_wa),
    .wd   (wb_val)
  );

  assign alu_b = ctrl.b_is_imm ? sext : rt_val;

  scp_alu #(.W(32)) u_alu (
    .a   (rs_val),
    .b   (alu_b),
    .ctl (alu_ctl),
    .y   (alu_y),
    .zero(alu_zero),
    .ovf (alu_ovf)
  );

  // Data store
  logic        daddr_ok, dm_we;
  logic [31:0] dm_rdata;
  assign daddr_ok = (alu_y[1:0] == 2'b00) && (alu_y[31:DAW+2] == '0);
  assign dm_we    = ctrl.mem_write && op_legal && daddr_ok && rst_n;
  assign dm_rdata = (ctrl.mem_read && daddr_ok) ? dmem[alu_y[DAW+1:2]] : '0;

  always_ff @(posedge clk) begin
    if (dmem_ld_en)  dmem[dmem_ld_addr]   <= dmem_ld_data;
    else if (dm_we)  dmem[alu_y[DAW+1:2]] <= rt_val;
  end

  assign dmem_obs_data = dmem[dmem_obs_addr];
  assign wb_val        = ctrl.wb_from_mem ? dm_rdata : alu_y;

  // Next PC
  scp_next_pc #(.W(32)) u_npc (
    .pc         (pc),
    .br_off     (f_imm),
    .jmp_field  (instr[25:0]),
    .take_branch(ctrl.branch && alu_zero),
    .take_jump  (ctrl.jump),
    .pc_next    (pc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

endmodule

// File: rtl/scp_core_chk.sv
module scp_core_chk
  import scp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        rf_we,
  input logic        dm_we,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);

  logic [5:0]  opc;
  logic [31:0] seq_ref, br_ref, jmp_ref;
  assign opc     = instr[31:26];
  assign seq_ref = pc + 32'd4;
  assign br_ref  = seq_ref + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_ref = {seq_ref[31:28], instr[25:0], 2'b00};

  AST_PC_RESET: assert property (@(posedge clk) !rst_n |=> (pc == 32'd0)); // R1
  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) !rst_n |-> (!rf_we && !dm_we)); // R1
  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (opc != OPC_BEQ && opc != OPC_JUMP) |=> (pc == $past(seq_ref))); // R2
  AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BEQ && rs_val == rt_val) |=> (pc == $past(br_ref))); // R6
  AST_BEQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BEQ && rs_val != rt_val) |=> (pc == $past(seq_ref))); // R6
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_JUMP) |=> (pc == $past(jmp_ref))); // R7
  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[25:21] == 5'd0) |-> (rs_val == 32'd0)); // R8
  AST_NO_RF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_STORE || opc == OPC_BEQ || opc == OPC_JUMP) |-> !rf_we); // R5
  AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && dm_we)); // R9

endmodule

bind scp_core scp_core_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .pc    (pc),
  .instr (instr),
  .rf_we (rf_we),
  .dm_we (dm_we),
  .rs_val(rs_val),
  .rt_val(rt_val)
);

// File: tb/sim_scp_core.sv
module sim_scp_core;

  localparam int CLK_PERIOD = 10;
  localparam int IAW = 6;
  localparam int DAW = 6;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_ld_en = 1'b0;
  logic [IAW-1:0] imem_ld_addr = '0;
  logic [31:0] imem_ld_data = '0;
  logic        dmem_ld_en = 1'b0;
  logic [DAW-1:0] dmem_ld_addr = '0;
  logic [31:0] dmem_ld_data = '0;
  logic [DAW-1:0] dmem_obs_addr = '0;
  logic [31:0] dmem_obs_data;
  logic        alu_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  scp_core #(.IAW(IAW), .DAW(DAW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .imem_ld_en(imem_ld_en), .imem_ld_addr(imem_ld_addr), .imem_ld_data(imem_ld_data),
    .dmem_ld_en(dmem_ld_en), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
    .dmem_obs_addr(dmem_obs_addr), .dmem_obs_data(dmem_obs_data),
    .alu_ovf(alu_ovf)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] prog  [DEPTH];
  logic [31:0] dinit [DEPTH];

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int word);
    return {6'h02, 26'(word)};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic peek(int idx, output logic [31:0] v);
    dmem_obs_addr = DAW'(idx);
    #1;
    v = dmem_obs_data;
  endtask

  task automatic clear_img();
    for (int i = 0; i < DEPTH; i++) begin
      prog[i]  = 32'h0000_0000;
      dinit[i] = 32'hD000_0000 + 32'(i);
    end
  endtask

  task automatic load_all();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      imem_ld_en = 1'b1; imem_ld_addr = IAW'(i); imem_ld_data = prog[i];
      dmem_ld_en = 1'b1; dmem_ld_addr = DAW'(i); dmem_ld_data = dinit[i];
      @(negedge clk);
    end
    imem_ld_en = 1'b0;
    dmem_ld_en = 1'b0;
  endtask

  task automatic release_run(int cycles);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    clear_img();
    prog[0] = enc_i(6'h2B, 0, 0, 0);   // store r0 to word 0
    prog[1] = enc_j(1);
    dinit[0] = 32'hCAFE_0001;
    load_all();
    repeat (10) @(negedge clk);
    peek(0, v); check("R1 no store in reset", v, 32'hCAFE_0001);
    release_run(3);
    peek(0, v); check("R1 first fetch at 0", v, 32'h0);
  endtask

  task automatic t_arith();
    logic [31:0] v;
    clear_img();
    dinit[0] = 32'hFFFF_FFFB; dinit[1] = 32'd7;
    prog[0]  = enc_i(6'h23, 0, 1, 0);
    prog[1]  = enc_i(6'h23, 0, 2, 4);
    prog[2]  = enc_r(1, 2, 3, 6'h20);
    prog[3]  = enc_r(1, 2, 4, 6'h22);
    prog[4]  = enc_r(1, 2, 5, 6'h24);
    prog[5]  = enc_r(1, 2, 6, 6'h25);
    prog[6]  = enc_r(1, 2, 7, 6'h2A);
    prog[7]  = enc_r(2, 1, 8, 6'h2A);
    for (int k = 0; k < 6; k++) prog[8+k] = enc_i(6'h2B, 0, 3+k, 8+4*k);
    prog[14] = enc_j(14);
    load_all();
    release_run(30);
    peek(2, v); check("R3 add", v, 32'h0000_0002);
    peek(3, v); check("R3 sub", v, 32'hFFFF_FFF4);
    peek(4, v); check("R3 and", v, 32'h0000_0003);
    peek(5, v); check("R3 or",  v, 32'hFFFF_FFFF);
    peek(6, v); check("R4 slt neg<pos", v, 32'd1);
    peek(7, v); check("R4 slt pos<neg", v, 32'd0);
  endtask

  task automatic t_zero_reg();
    logic [31:0] v;
    clear_img();
    dinit[0] = 32'd5; dinit[1] = 32'hFFFF;
    prog[0] = enc_i(6'h23, 0, 1, 0);
    prog[1] = enc_r(1, 1, 0, 6'h20);    // add into r0
    prog[2] = enc_i(6'h23, 0, 0, 0);    // load into r0
    prog[3] = enc_i(6'h2B, 0, 0, 4);
    prog[4] = enc_r(0, 1, 2, 6'h20);
    prog[5] = enc_i(6'h2B, 0, 2, 8);
    prog[6] = enc_j(6);
    load_all();
    release_run(20);
    peek(1, v); check("R8 r0 stays zero", v, 32'd0);
    peek(2, v); check("R8 r0 as operand", v, 32'd5);
  endtask

  task automatic t_branch();
    logic [31:0] v;
    clear_img();
    dinit[0] = 32'd11; dinit[1] = 32'd22; dinit[3] = 32'h55;
    prog[0] = enc_i(6'h23, 0, 1, 0);
    prog[1] = enc_i(6'h23, 0, 2, 4);
    prog[2] = enc_i(6'h04, 1, 2, 1);    // not taken
    prog[3] = enc_i(6'h2B, 0, 1, 8);
    prog[4] = enc_i(6'h04, 1, 1, 1);    // taken to 6
    prog[5] = enc_i(6'h2B, 0, 2, 12);
    prog[6] = enc_i(6'h2B, 0, 2, 16);
    prog[7] = enc_j(7);
    load_all();
    release_run(20);
    peek(2, v); check("R6 fall through", v, 32'd11);
    peek(3, v); check("R6 taken skips", v, 32'h55);
    peek(4, v); check("R6 target", v, 32'd22);
  endtask

  task automatic t_loop();
    logic [31:0] v;
    clear_img();
    dinit[0] = 32'd3; dinit[1] = 32'd1; dinit[2] = 32'd10;
    prog[0] = enc_i(6'h23, 0, 3, 0);
    prog[1] = enc_i(6'h23, 0, 4, 4);
    prog[2] = enc_i(6'h23, 0, 1, 8);
    prog[3] = enc_r(0, 0, 5, 6'h20);
    prog[4] = enc_r(5, 1, 5, 6'h20);
    prog[5] = enc_r(3, 4, 3, 6'h22);
    prog[6] = enc_i(6'h04, 3, 0, 1);
    prog[7] = enc_i(6'h04, 0, 0, -4);   // backward
    prog[8] = enc_i(6'h2B, 0, 5, 12);
    prog[9] = enc_j(9);
    load_all();
    release_run(40);
    peek(3, v); check("R6 backward loop", v, 32'd30);
  endtask

  task automatic t_jump();
    logic [31:0] v;
    clear_img();
    dinit[0] = 32'h77;
    prog[0] = enc_i(6'h23, 0, 1, 0);
    prog[1] = enc_j(4);
    prog[2] = enc_i(6'h2B, 0, 1, 4);
    prog[3] = enc_i(6'h2B, 0, 1, 8);
    prog[4] = enc_i(6'h2B, 0, 1, 12);
    prog[5] = enc_j(5);
    load_all();
    release_run(20);
    peek(1, v); check("R7 skipped 1", v, 32'hD000_0001);
    peek(2, v); check("R7 skipped 2", v, 32'hD000_0002);
    peek(3, v); check("R7 target", v, 32'h77);
  endtask

  task automatic t_ldst();
    logic [31:0] v;
    clear_img();
    dinit[0] = 32'd32; dinit[6] = 32'hA5A5_1234;
    prog[0] = enc_i(6'h23, 0, 1, 0);
    prog[1] = enc_i(6'h23, 1, 2, -8);
    prog[2] = enc_i(6'h2B, 1, 2, -4);
    prog[3] = enc_j(3);
    load_all();
    release_run(15);
    peek(7, v); check("R5 negative offset", v, 32'hA5A5_1234);
    peek(8, v); check("R5 base word intact", v, 32'hD000_0008);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    clear_img();
    dinit[0] = 32'h1111; dinit[2] = 32'h2222;
    prog[0] = enc_i(6'h23, 0, 1, 0);
    prog[1] = enc_i(6'h3F, 0, 1, 8);                // unknown opcode
    prog[2] = enc_r(1, 1, 1, 6'h27);                // unsupported function
    prog[3] = {6'h00, 5'd1, 5'd1, 5'd1, 5'd3, 6'h20}; // shamt not zero
    prog[4] = enc_i(6'h2B, 0, 1, 4);
    prog[5] = enc_j(5);
    load_all();
    release_run(20);
    peek(1, v); check("R9 register untouched", v, 32'h1111);
    peek(2, v); check("R9 no data write", v, 32'h2222);
  endtask

  task automatic t_ovf();
    clear_img();
    dinit[0] = 32'h7FFF_FFFF; dinit[1] = 32'h8000_0000;
    prog[0] = enc_i(6'h23, 0, 1, 0);
    prog[1] = enc_i(6'h23, 0, 4, 4);
    prog[2] = enc_r(1, 1, 2, 6'h20);
    prog[3] = enc_r(1, 1, 3, 6'h22);
    prog[4] = enc_r(4, 1, 5, 6'h22);
    prog[5] = enc_r(4, 1, 6, 6'h24);
    prog[6] = enc_j(6);
    load_all();
    release_run(2);
    check("R10 add overflow", 32'(alu_ovf), 32'd1);
    @(negedge clk);
    check("R10 sub no overflow", 32'(alu_ovf), 32'd0);
    @(negedge clk);
    check("R10 sub overflow", 32'(alu_ovf), 32'd1);
    @(negedge clk);
    check("R10 and clears flag", 32'(alu_ovf), 32'd0);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_zero_reg();
    t_branch();
    t_loop();
    t_jump();
    t_ldst();
    t_illegal();
    t_ovf();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule